// File: doc/BRIEF.md
# Stereo DC-Offset Removal Stage

This block sits right after an audio ADC's decimator. It takes a stereo stream of signed PCM words, one left and one right word per frame strobe. For each channel it tracks the DC bias with a leaky-integrator running average and subtracts that estimate from the sample. The result is a zero-centred stream that appears one clock after the strobe, together with its own valid flag.

An 8-bit control byte sets the behaviour:

- Offset removal can be bypassed, so samples pass through unchanged.
- The estimate can be frozen. The held value is still subtracted, so later DC changes pass through.
- Each channel can be muted on its own.

The estimator is `acc += (x·2^K − acc) >>> K` on a fixed-point accumulator with K fractional bits. The subtracted offset is `acc >>> K`, which is the floor. The subtraction saturates.

Top module: `dc_offset_remover`

## Requirements
- R1: After reset, `out_valid`, `out_l` and `out_r` are 0. Both offset estimates are 0, so the first active frame outputs the input unchanged.
- R2: When `ctrl[5]` is 1, removal is bypassed and each unmuted channel outputs its input sample exactly. The estimates are not updated while `ctrl[5]` is 1.
- R3: When `ctrl[5]` and `ctrl[4]` are both 0, each valid frame outputs `sat(x − (acc >>> K))` using the accumulator value from before the frame. After that, the accumulator becomes `acc + ((x·2^K − acc) >>> K)`, with an arithmetic shift.
- R4: When `ctrl[4]` is 1 and `ctrl[5]` is 0, the accumulator holds its value, and the held estimate is still subtracted from every sample.
- R5: `ctrl[7]` forces `out_l` to 0 and `ctrl[6]` forces `out_r` to 0. Each acts on its own channel only, and muting does not stop that channel's estimator.
- R6: The subtraction result is clamped to the range −2^(W−1) to 2^(W−1)−1 instead of wrapping.
- R7: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `out_l` and `out_r` hold their values.
- R8: `ctrl[3:0]` has no effect on any output or on the estimates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame strobe; both samples are valid |
| ctrl | input | 8 | Bit 7: left mute. Bit 6: right mute. Bit 5: removal off. Bit 4: freeze. Bits 3:0: unused |
| in_l | input | W | Left input sample, signed |
| in_r | input | W | Right input sample, signed |
| out_valid | output | 1 | Output frame valid |
| out_l | output | W | Left output sample, signed |
| out_r | output | W | Right output sample, signed |

## Verification
The bench holds a long DC level until the estimates converge. It then freezes the estimates and steps the inputs to the opposite extreme, so the left result must clamp at the negative limit and the right one at the positive limit. A design that wraps would show a full-scale sign flip at that point. A design that kept updating while frozen would show the output drifting back toward zero.

Bypass and mute frames are interleaved with gaps in the strobe. A design that updated the estimate during bypass, or that stopped it during mute, would diverge from the bench model on later frames. The reserved bits are randomised throughout, and an off-by-one in the floor shift would appear as a one-LSB error on negative offsets.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef struct packed {
    logic       mute_l;
    logic       mute_r;
    logic       hp_off;
    logic       freeze;
    logic [3:0] spare;
  } dcr_ctrl_t;
endpackage

// File: rtl/dcr_tracker.sv
module dcr_tracker #(
  parameter int W = 24,
  parameter int K = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic signed [W-1:0]   x,
  output logic signed [W-1:0]   est,
  output logic [W+K:0]          acc_o
);
  localparam int AW = W + K + 1;

  logic signed [AW-1:0] acc_q;

  // one leaky-integrator step with flooring arithmetic shift
  function automatic logic [AW-1:0] leak_step(input logic [AW-1:0] a,
                                              input logic [W-1:0]  s);
    logic signed [AW:0] tgt;
    logic signed [AW:0] d;
    logic signed [AW:0] st;
    tgt = $signed({{2{s[W-1]}}, s, {K{1'b0}}});
    d   = tgt - $signed({a[AW-1], a});
    st  = d >>> K;
    return a + st[AW-1:0];
  endfunction

  logic signed [AW-1:0] acc_sh;
  assign acc_sh = acc_q >>> K;
  assign est    = acc_sh[W-1:0];
  assign acc_o  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (upd) acc_q <= $signed(leak_step(acc_q, x));
  end
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan #(
  parameter int W = 24,
  parameter int K = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld,
  input  logic                hp_off,
  input  logic                freeze,
  input  logic                mute,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y,
  output logic [W+K:0]        acc_o
);
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] est;
  logic                upd;
  logic signed [W-1:0] y_n;

  assign upd = vld & ~hp_off & ~freeze;

  dcr_tracker #(.W(W), .K(K)) u_trk (
    .clk(clk), .rst_n(rst_n), .upd(upd), .x(x), .est(est), .acc_o(acc_o)
  );

  // difference clamped to the signed sample range
  function automatic logic [W-1:0] sat_sub(input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [W:0] d;
    d = {a[W-1], a} - {b[W-1], b};
    if (d[W] != d[W-1]) return d[W] ? SMIN : SMAX;
    return d[W-1:0];
  endfunction

  always_comb begin
    if (mute)        y_n = '0;
    else if (hp_off) y_n = x;
    else             y_n = $signed(sat_sub(x, est));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y <= '0;
    else if (vld) y <= y_n;
  end
endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover #(
  parameter int W = 24,
  parameter int K = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          ctrl,
  input  logic signed [W-1:0] in_l,
  input  logic signed [W-1:0] in_r,
  output logic                out_valid,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r
);
  import dcr_pkg::*;
  localparam int NCH = 2;
  localparam int AW  = W + K + 1;

  dcr_ctrl_t           cfg;
  logic [W-1:0]        x_in  [NCH];
  logic [W-1:0]        y_out [NCH];
  logic [NCH-1:0]      mute_v;
  logic [AW-1:0]       acc_v [NCH];
  logic [AW-1:0]       acc_l;
  logic [AW-1:0]       acc_r;

  assign cfg      = dcr_ctrl_t'(ctrl);
  assign x_in[0]  = in_l;
  assign x_in[1]  = in_r;
  assign mute_v   = {cfg.mute_r, cfg.mute_l};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [W-1:0] y_c;
    dcr_chan #(.W(W), .K(K)) u_ch (
      .clk(clk), .rst_n(rst_n), .vld(in_valid),
      .hp_off(cfg.hp_off), .freeze(cfg.freeze), .mute(mute_v[c]),
      .x($signed(x_in[c])), .y(y_c), .acc_o(acc_v[c])
    );
    assign y_out[c] = y_c;
  end

  assign out_l = $signed(y_out[0]);
  assign out_r = $signed(y_out[1]);
  assign acc_l = acc_v[0];
  assign acc_r = acc_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int W = 24,
  parameter int K = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [7:0]     ctrl,
  input logic [W-1:0]   in_l,
  input logic [W-1:0]   in_r,
  input logic           out_valid,
  input logic [W-1:0]   out_l,
  input logic [W-1:0]   out_r,
  input logic [W+K:0]   acc_l,
  input logic [W+K:0]   acc_r
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_l) && $stable(out_r)));
  a_r5_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[7]) |=> (out_l == '0));
  a_r5_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[6]) |=> (out_r == '0));
  a_r2_bypass_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[5] && !ctrl[7]) |=> (out_l == $past(in_l)));
  a_r2_bypass_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[5] && !ctrl[6]) |=> (out_r == $past(in_r)));
  a_r4_est_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] || ctrl[5] || !in_valid) |=> ($stable(acc_l) && $stable(acc_r)));
endmodule

bind dc_offset_remover dcr_checker #(.W(W), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
  .in_l(in_l), .in_r(in_r), .out_valid(out_valid),
  .out_l(out_l), .out_r(out_r), .acc_l(acc_l), .acc_r(acc_r)
);

// File: tb/dc_offset_remover_tb.sv
module dc_offset_remover_tb;
  localparam int W = 16;
  localparam int K = 10;
  localparam longint SMAX = (64'sd1 <<< (W-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] ctrl = '0;
  logic signed [W-1:0] in_l = '0, in_r = '0;
  logic out_valid;
  logic signed [W-1:0] out_l, out_r;

  int n_chk = 0, n_fail = 0;
  longint acc [2];
  longint exp_y [2];
  bit exp_v;

  always #2 clk = ~clk;

  dc_offset_remover #(.W(W), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r)
  );

  function automatic longint clamp(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic chk(string tag, longint got, longint expv);
    n_chk++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  // one cycle: drive, update model, compare after the edge
  task automatic step(bit v, logic [7:0] c, longint l, longint r, string force_tag = "");
    string tag [2];
    @(negedge clk);
    in_valid = v; ctrl = c;
    in_l = W'(l); in_r = W'(r);
    for (int ch = 0; ch < 2; ch++) begin
      longint x, est, raw;
      bit mute;
      x    = ch ? longint'(in_r) : longint'(in_l);
      mute = ch ? c[6] : c[7];
      if (!v) tag[ch] = "R7";
      else begin
        est = acc[ch] >>> K;
        raw = x - est;
        if (mute)      begin exp_y[ch] = 0; tag[ch] = "R5"; end
        else if (c[5]) begin exp_y[ch] = x; tag[ch] = "R2"; end
        else begin
          exp_y[ch] = clamp(raw);
          if (raw != exp_y[ch]) tag[ch] = "R6";
          else if (c[4])        tag[ch] = "R4";
          else if (c[3:0] != 0) tag[ch] = "R8";
          else                  tag[ch] = "R3";
        end
        if (!c[5] && !c[4]) acc[ch] = acc[ch] + (((x <<< K) - acc[ch]) >>> K);
      end
      if (force_tag != "") tag[ch] = force_tag;
    end
    exp_v = v;
    @(posedge clk); #1;
    chk("R7 out_valid", longint'(out_valid), longint'(exp_v));
    chk({tag[0], " out_l"}, longint'(out_l), exp_y[0]);
    chk({tag[1], " out_r"}, longint'(out_r), exp_y[1]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    acc[0] = 0; acc[1] = 0; exp_y[0] = 0; exp_y[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out_valid", longint'(out_valid), 0);
    chk("R1 reset out_l", longint'(out_l), 0);
    chk("R1 reset out_r", longint'(out_r), 0);
    @(negedge clk); rst_n = 1'b1;

    // first active frame sees zero estimates
    step(1, 8'h00, 1234, -777, "R1");

    // DC build-up, converging estimates (R3), with reserved bits set (R8)
    for (int i = 0; i < 7000; i++)
      step(1, (i % 5 == 0) ? 8'h0A : 8'h00, 20000 + $signed($urandom_range(0, 30)) - 15,
           -12000 + $signed($urandom_range(0, 30)) - 15);

    // freeze, then step to the opposite extremes: clamps (R4, R6)
    for (int i = 0; i < 50; i++) step(1, 8'h10, 20000, -12000);
    for (int i = 0; i < 20; i++) step(1, 8'h10, -30000, 30000);
    step(1, 8'h10, SMIN, SMAX);
    step(0, 8'h10, 0, 0);

    // per-channel mute with gaps (R5, R7)
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 3) != 0, (i < 100) ? 8'h80 : 8'h40,
           $signed($urandom_range(0, 65535)) - 32768, $signed($urandom_range(0, 65535)) - 32768);

    // bypass: estimates frozen by disable (R2)
    for (int i = 0; i < 300; i++)
      step(1, 8'h20 | 8'($urandom_range(0, 15)),
           $signed($urandom_range(0, 65535)) - 32768, $signed($urandom_range(0, 65535)) - 32768);

    // random mix of everything
    for (int i = 0; i < 20000; i++) begin
      longint l, r;
      l = ($urandom_range(0, 19) == 0) ? SMIN : $signed($urandom_range(0, 65535)) - 32768;
      r = ($urandom_range(0, 19) == 0) ? SMAX : $signed($urandom_range(0, 65535)) - 32768;
      step($urandom_range(0, 4) != 0, 8'($urandom), l, r);
    end

    finish_run();
  end
endmodule